// File: doc/BRIEF.md
# Status LED Pattern Sequencer

This block drives a single board status LED. It reports the board condition through repeating eight-slot blink patterns: a steady fast blink while the carrier asserts its reset, a distinct pattern after software has changed the boot mode, another after software has moved the bank-voltage select pin, and a steady glow when nothing has happened since power-up. Software can also take the LED over completely by writing control codes to a register.

An upstream serial register slave supplies decoded writes as address, data and a one-cycle valid strobe. Upstream logic supplies the two software events as one-cycle pulses. The slot timebase is built inside the block from the system clock, and every slot lasts a parameterised number of cycles. The carrier reset input must already be synchronous to `clk`.

Top module: `led_status_seq`

## Requirements
- R1: While the power-on reset `rst` is high, `led` is low and both the override and the event memory are cleared. Once `rst` is released, the LED shows the default state.
- R2: With no override, no carrier reset and no event since power-on, `led` is continuously high.
- R3: While `carrier_rst_n` is low, the LED is lit in even slots and dark in odd slots, so it toggles once per slot. This takes precedence over every other state, including the override.
- R4: After a boot-mode event (`boot_evt` pulse), the LED is lit in slots 0 to 3 and dark in slots 4 to 7 of every frame.
- R5: After a bank-voltage event (`bank_evt` pulse), the LED is lit in slots 0 to 2 and dark in slots 3 to 7 of every frame.
- R6: A write of data 0xA0 to address 0x03 forces the LED dark, and a write of 0xA1 to address 0x03 forces it lit. The override outranks the event patterns and the default state.
- R7: A write of data 0x00 to address 0x03 cancels the override and returns the LED to the automatic status display.
- R8: A write to address 0x03 with any other data value has no effect on the LED. A write to any other address has no effect either.
- R9: The event memory holds through carrier resets and is cleared only by `rst`. The most recent event type decides the pattern. If both pulses arrive in the same cycle, the bank-voltage pattern wins.
- R10: Slot 0 begins at the release of `rst`. The slot index advances every `SLOT_CYCLES` clock cycles and wraps after slot 7. The LED output is registered, so it shows the state and slot as they stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| carrier_rst_n | input | 1 | Carrier reset indication, active low, synchronous to clk |
| boot_evt | input | 1 | One-cycle pulse when software changes the boot mode |
| bank_evt | input | 1 | One-cycle pulse when software changes the bank-voltage pin |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| led | output | 1 | LED drive, high = lit |

## Verification
The bench builds the block with `SLOT_CYCLES` set to 4 instead of the full-rate default of about three million. At that value one eight-slot frame lasts 32 cycles, so each pattern runs through several complete frames within each scenario. The wrap from slot 7 back to slot 0, the hand-over between patterns and the priority changes at the carrier reset edges all come within reach of a cycle-exact comparison across the whole run.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

    localparam int unsigned PAT_SLOTS = 8;
    localparam int unsigned SLOT_W    = $clog2(PAT_SLOTS);
    localparam int unsigned REG_AW    = 8;
    localparam int unsigned REG_DW    = 8;

    localparam logic [REG_AW-1:0] OVR_REG_ADDR = 8'h03;
    localparam logic [REG_DW-1:0] CODE_DARK    = 8'hA0;
    localparam logic [REG_DW-1:0] CODE_LIT     = 8'hA1;
    localparam logic [REG_DW-1:0] CODE_AUTO    = 8'h00;

    // Number of lit slots at the head of each event frame
    localparam int unsigned BOOT_LIT_SLOTS = 4;
    localparam int unsigned BANK_LIT_SLOTS = 3;

    typedef enum logic [1:0] {OVR_AUTO, OVR_DARK, OVR_LIT} ovr_e;
    typedef enum logic [1:0] {EVT_NONE, EVT_BOOT, EVT_BANK} evt_e;
    typedef enum logic [2:0] {
        SHOW_STEADY, SHOW_BOOT, SHOW_BANK, SHOW_FAST, SHOW_DARK, SHOW_LIT
    } show_e;

    typedef struct packed {
        ovr_e ovr;
        evt_e evt;
    } mode_t;

    // Priority: carrier reset > override > latest event > steady
    function automatic show_e pick_show(logic carrier_active, mode_t m);
        show_e s;
        if (carrier_active)          s = SHOW_FAST;
        else if (m.ovr == OVR_DARK)  s = SHOW_DARK;
        else if (m.ovr == OVR_LIT)   s = SHOW_LIT;
        else if (m.evt == EVT_BANK)  s = SHOW_BANK;
        else if (m.evt == EVT_BOOT)  s = SHOW_BOOT;
        else                         s = SHOW_STEADY;
        return s;
    endfunction

    function automatic logic pattern_bit(show_e s, logic [SLOT_W-1:0] slot);
        logic b;
        case (s)
            SHOW_FAST: b = ~slot[0];
            SHOW_BOOT: b = (32'(slot) < BOOT_LIT_SLOTS);
            SHOW_BANK: b = (32'(slot) < BANK_LIT_SLOTS);
            SHOW_DARK: b = 1'b0;
            default:   b = 1'b1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/led_slot_timer.sv
module led_slot_timer
    import led_seq_pkg::*;
#(
    parameter int unsigned SLOT_CYCLES = 3_022_500
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot
);
    localparam int unsigned CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             slot_end;

    assign slot_end = (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            slot <= '0;
        end else if (slot_end) begin
            cnt  <= '0;
            slot <= slot + 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        slot_end |=> (slot == $past(slot) + 1'b1)); // R10
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !slot_end |=> $stable(slot)); // R10
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_LAST); // R10

endmodule

// File: rtl/led_mode_regs.sv
module led_mode_regs
    import led_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_evt,
    input  logic              bank_evt,
    input  logic              wr_valid,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    output mode_t             mode
);
    logic hit;
    assign hit = wr_valid && (wr_addr == OVR_REG_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode.ovr <= OVR_AUTO;
            mode.evt <= EVT_NONE;
        end else begin
            if (hit) begin
                case (wr_data)
                    CODE_DARK: mode.ovr <= OVR_DARK;
                    CODE_LIT:  mode.ovr <= OVR_LIT;
                    CODE_AUTO: mode.ovr <= OVR_AUTO;
                    default:   mode.ovr <= mode.ovr;
                endcase
            end
            if (bank_evt)      mode.evt <= EVT_BANK;
            else if (boot_evt) mode.evt <= EVT_BOOT;
        end
    end

    AST_OVR_DARK: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr == 8'h03 && wr_data == 8'hA0) |=> mode.ovr == OVR_DARK); // R6
    AST_OVR_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_addr == 8'h03 && wr_data == 8'h00) |=> mode.ovr == OVR_AUTO); // R7
    AST_OVR_IGNORE: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && wr_addr == 8'h03 && (wr_data == 8'hA0 || wr_data == 8'hA1 || wr_data == 8'h00))
        |=> $stable(mode.ovr)); // R8
    AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (mode.evt != EVT_NONE) |=> (mode.evt != EVT_NONE)); // R9
    AST_BANK_WINS: assert property (@(posedge clk) disable iff (rst)
        bank_evt |=> mode.evt == EVT_BANK); // R9

endmodule

// File: rtl/led_status_seq.sv
module led_status_seq
    import led_seq_pkg::*;
#(
    parameter int unsigned SLOT_CYCLES = 3_022_500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       carrier_rst_n,
    input  logic       boot_evt,
    input  logic       bank_evt,
    input  logic       wr_valid,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       led
);
    logic [SLOT_W-1:0] slot;
    mode_t             mode;
    show_e             show;

    led_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    led_mode_regs u_mode (
        .clk      (clk),
        .rst      (rst),
        .boot_evt (boot_evt),
        .bank_evt (bank_evt),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .mode     (mode)
    );

    assign show = pick_show(!carrier_rst_n, mode);

    always_ff @(posedge clk) begin
        if (rst) led <= 1'b0;
        else     led <= pattern_bit(show, slot);
    end

    AST_FAST_BLINK: assert property (@(posedge clk) disable iff (rst)
        !carrier_rst_n |=> (led == ~$past(slot[0]))); // R3
    AST_FORCED_DARK: assert property (@(posedge clk) disable iff (rst)
        (carrier_rst_n && mode.ovr == OVR_DARK) |=> !led); // R6
    AST_FORCED_LIT: assert property (@(posedge clk) disable iff (rst)
        (carrier_rst_n && mode.ovr == OVR_LIT) |=> led); // R6
    AST_STEADY: assert property (@(posedge clk) disable iff (rst)
        (carrier_rst_n && mode.ovr == OVR_AUTO && mode.evt == EVT_NONE) |=> led); // R2

endmodule

// File: tb/led_status_seq_test.sv
`timescale 1ns/100ps
module led_status_seq_test;
    localparam int unsigned SLOT = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       carrier_rst_n = 1'b1;
    logic       boot_evt = 1'b0;
    logic       bank_evt = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       led;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string ctx = "";

    // scoreboard
    bit    exp_q[$];
    string tag_q[$];

    // reference state: override 0 auto,1 dark,2 lit; event 0 none,1 boot,2 bank
    int m_ovr, m_evt, m_cnt, m_slot;

    always #2.5 clk = ~clk;

    led_status_seq #(.SLOT_CYCLES(SLOT)) uut (
        .clk(clk), .rst(rst), .carrier_rst_n(carrier_rst_n),
        .boot_evt(boot_evt), .bank_evt(bank_evt),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .led(led)
    );

    task automatic check(bit act, bit exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s led actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: compares the previous prediction, then predicts the next edge
    always @(negedge clk) begin
        if (rst) begin
            exp_q.delete(); tag_q.delete();
            m_ovr = 0; m_evt = 0; m_cnt = 0; m_slot = 0;
        end else begin
            bit e; string t;
            if (exp_q.size() > 0) check(led, exp_q.pop_front(), tag_q.pop_front());
            if (!carrier_rst_n)  begin e = (m_slot % 2 == 0); t = "R3"; end
            else if (m_ovr == 1) begin e = 0; t = "R6"; end
            else if (m_ovr == 2) begin e = 1; t = "R6"; end
            else if (m_evt == 2) begin e = (m_slot < 3); t = "R5"; end
            else if (m_evt == 1) begin e = (m_slot < 4); t = "R4"; end
            else                 begin e = 1; t = "R2"; end
            if (ctx != "") t = ctx;
            exp_q.push_back(e); tag_q.push_back(t);
            if (wr_valid && wr_addr == 8'h03) begin
                if (wr_data == 8'hA0) m_ovr = 1;
                else if (wr_data == 8'hA1) m_ovr = 2;
                else if (wr_data == 8'h00) m_ovr = 0;
            end
            if (bank_evt) m_evt = 2;
            else if (boot_evt) m_evt = 1;
            if (m_cnt == SLOT - 1) begin m_cnt = 0; m_slot = (m_slot + 1) % 8; end
            else m_cnt++;
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic reg_write(logic [7:0] a, logic [7:0] d);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic pulse(bit boot, bit bank);
        @(posedge clk); #1;
        boot_evt = boot; bank_evt = bank;
        @(posedge clk); #1;
        boot_evt = 1'b0; bank_evt = 1'b0;
    endtask

    task automatic set_carrier(logic v);
        @(posedge clk); #1;
        carrier_rst_n = v;
    endtask

    task automatic power_reset();
        @(posedge clk); #1; rst = 1'b1;
        idle(4);
        @(negedge clk); check(led, 1'b0, "R1");
        @(posedge clk); #1; rst = 1'b0;
    endtask

    initial begin
        idle(5);
        @(negedge clk); check(led, 1'b0, "R1");
        @(posedge clk); #1; rst = 1'b0;
        ctx = "R1"; idle(6); ctx = "";
        idle(40);                                   // R2 steady
        pulse(1, 0); idle(70);                      // R4 boot pattern
        set_carrier(1'b0); idle(70);                // R3 fast blink
        set_carrier(1'b1); ctx = "R9"; idle(40); ctx = "";
        reg_write(8'h03, 8'hA1); idle(40);          // R6 lit
        ctx = "R8"; reg_write(8'h03, 8'h55); idle(40);
        reg_write(8'h04, 8'hA0); idle(20); ctx = "";
        reg_write(8'h03, 8'hA0); idle(40);          // R6 dark
        set_carrier(1'b0); idle(40);                // R3 beats override
        set_carrier(1'b1); idle(10);
        ctx = "R7"; reg_write(8'h03, 8'h00); idle(40); ctx = "";
        pulse(0, 1); idle(40);                      // R5 bank pattern
        ctx = "R10"; idle(64); ctx = "";
        ctx = "R9"; pulse(1, 0); idle(40);
        pulse(1, 1); idle(40); ctx = "";
        power_reset();
        ctx = "R1"; idle(40); ctx = "";
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-R actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule